// File: doc/BRIEF.md
# User Refresh Request Generator

This block lives in the programmable fabric next to a memory controller that has been set up to take its refreshes from user logic. It keeps time with a programmable refresh-interval timer in the fabric clock domain. For every request lane it keeps a count of refreshes that are owed but not yet handed over. A lane is one physical rank of one channel. Each owed refresh is passed to the controller through a four-phase enable/acknowledge handshake, one handshake per lane.

The acknowledge vector and the calibration-done flag come from the controller's clock domain. Both pass through a multi-flop synchronizer before any logic uses them. A rank mask selects which ranks are served. A group setting makes all active lanes start their handshakes on the same cycle, which suits stacked multi-rank devices. A lockstep setting also drives the lanes of the secondary channel with the same mask, so a single-channel system can feed the unused channel. Two status outputs report problems. One flags a lane whose acknowledge is late. The other is a sticky flag that rises when any lane falls too far behind.

Top module: `ref_req_gen`

## Requirements
- R1: No bit of `ref_en` is raised before the synchronized calibration-done flag has been seen high. The interval timer only starts counting from that point, so no refresh is owed for the time before it.
- R2: Each lane follows this order. The enable rises only while its acknowledge is low. It then stays high until the acknowledge is seen high, and after it drops it rises again only once the acknowledge has been seen low.
- R3: Outside group mode each lane runs on its own. A lane whose acknowledge never arrives does not delay service to the other lanes.
- R4: Acknowledge inputs pass through `SYNC_STAGES` flops. An enable falls no earlier than `SYNC_STAGES`+1 clock cycles after its acknowledge rises.
- R5: Each time `cfg_interval` cycles elapse, every active lane is owed one more refresh, and each owed refresh produces exactly one handshake. A `cfg_interval` of 0 stops the timer.
- R6: Lane index is channel*`NUM_RANKS`+rank. A lane is active when its rank bit in `cfg_rank_mask` is 1. Active lanes receive equal numbers of requests, and inactive lanes never raise their enable.
- R7: When acknowledges return promptly, successive enable rises on a lane are never more than seven refresh intervals apart.
- R8: `owed_err` is set, and stays set until reset, once any lane owes `MAX_OWED` (6) refreshes. It stays low while every lane keeps up.
- R9: If a lane's acknowledge has not been seen `cfg_ack_timeout` cycles after its enable rose, that lane's bit of `ack_timeout` is set and stays set until reset. The enable remains high (a `cfg_ack_timeout` of 0 turns this check off).
- R10: With `cfg_group` = 1 a new handshake starts only when every active lane is idle and owes a refresh. All active lanes then raise their enables on the same cycle.
- R11: With `cfg_lockstep_ch` = 1 the lanes of channels above 0 are active under the same rank mask and receive the same requests. With it 0 their enables stay low.
- R12: While the synchronized calibration-done flag is low, no handshake starts. A handshake already in progress runs to completion, and refreshes that are owed are served once the flag returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_done_async | input | 1 | Calibration-done / port-available flag from the controller domain |
| ref_ack_async | input | NUM_CH*NUM_RANKS | Per-lane acknowledge from the controller domain |
| cfg_interval | input | IVL_W | Refresh interval in clock cycles, 0 stops the timer |
| cfg_rank_mask | input | NUM_RANKS | Active ranks |
| cfg_group | input | 1 | Start all active lanes together |
| cfg_lockstep_ch | input | 1 | Also serve channels above 0 with the same mask |
| cfg_ack_timeout | input | TO_W | Acknowledge timeout in cycles, 0 turns it off |
| ref_en | output | NUM_CH*NUM_RANKS | Per-lane refresh enable (registered) |
| owed_err | output | 1 | Sticky: a lane reached the postponement limit |
| ack_timeout | output | NUM_CH*NUM_RANKS | Sticky per-lane acknowledge timeout |

## Verification
The controller is modelled as a responder that echoes each enable after a delay set per lane. With mixed short delays the request counts must match the elapsed intervals exactly on every active lane. This separates correct timer accounting from lost or doubled handshakes, and it also measures the acknowledge-to-release latency and the largest gap between requests. A responder that stays silent on one lane shows that the other lanes are unaffected, that the timeout flag rises while the enable is held, and that the postponement flag fires. Group mode with very uneven delays shows whether starts are aligned. Holding calibration-done low, and dropping it in the middle of a handshake, shows the difference between blocking new starts and abandoning a handshake already under way.

// File: rtl/ref_gen_pkg.sv
package ref_gen_pkg;
  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_REQ  = 2'd1,
    HS_DROP = 2'd2
  } hs_state_t;
endpackage

// File: rtl/ref_sync.sv
module ref_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] cfg_interval,
  output logic         tick
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run || cfg_interval == '0) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= cfg_interval - 1'b1) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/ref_lane.sv
module ref_lane
  import ref_gen_pkg::*;
#(
  parameter int MAX_OWED = 6,
  parameter int TO_W     = 8,
  localparam int OWED_W  = $clog2(MAX_OWED + 2)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            go,
  input  logic            ack_s,
  input  logic [TO_W-1:0] cfg_timeout,
  output logic            en,
  output logic            idle,
  output logic            pending,
  output logic            owed_hi,
  output logic            timeout
);
  hs_state_t         state;
  logic [OWED_W-1:0] owed;
  logic [TO_W-1:0]   tcnt;
  logic              done;

  assign done    = (state == HS_DROP) && !ack_s;
  assign idle    = (state == HS_IDLE);
  assign pending = (owed != '0);
  assign owed_hi = (owed >= OWED_W'(MAX_OWED));

  always_ff @(posedge clk) begin
    if (rst) begin
      owed <= '0;
    end else begin
      case ({tick, done})
        2'b10:   if (owed != '1) owed <= owed + 1'b1;
        2'b01:   if (owed != '0) owed <= owed - 1'b1;
        default: owed <= owed;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= HS_IDLE;
      en      <= 1'b0;
      tcnt    <= '0;
      timeout <= 1'b0;
    end else begin
      case (state)
        HS_IDLE: begin
          if (go && pending) begin
            state <= HS_REQ;
            en    <= 1'b1;
            tcnt  <= '0;
          end
        end
        HS_REQ: begin
          if (ack_s) begin
            state <= HS_DROP;
            en    <= 1'b0;
          end else if (cfg_timeout != '0) begin
            if (tcnt != cfg_timeout) tcnt <= tcnt + 1'b1;
            else                     timeout <= 1'b1;
          end
        end
        HS_DROP: begin
          if (!ack_s) state <= HS_IDLE;
        end
        default: begin
          state <= HS_IDLE;
          en    <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/ref_req_gen.sv
module ref_req_gen #(
  parameter int NUM_RANKS   = 4,
  parameter int NUM_CH      = 2,
  parameter int IVL_W       = 16,
  parameter int TO_W        = 8,
  parameter int SYNC_STAGES = 2,
  parameter int MAX_OWED    = 6,
  localparam int LANES      = NUM_CH * NUM_RANKS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cal_done_async,
  input  logic [LANES-1:0]     ref_ack_async,
  input  logic [IVL_W-1:0]     cfg_interval,
  input  logic [NUM_RANKS-1:0] cfg_rank_mask,
  input  logic                 cfg_group,
  input  logic                 cfg_lockstep_ch,
  input  logic [TO_W-1:0]      cfg_ack_timeout,
  output logic [LANES-1:0]     ref_en,
  output logic                 owed_err,
  output logic [LANES-1:0]     ack_timeout
);
  logic [LANES-1:0] ack_s;
  logic             cal_ok;
  logic             cal_seen;
  logic             tick;
  logic [LANES-1:0] active;
  logic [LANES-1:0] idle;
  logic [LANES-1:0] pending;
  logic [LANES-1:0] owed_hi;
  logic             group_go;

  ref_sync #(.W(LANES + 1), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cal_done_async, ref_ack_async}),
    .q   ({cal_ok, ack_s})
  );

  always_ff @(posedge clk) begin
    if (rst) cal_seen <= 1'b0;
    else     cal_seen <= cal_seen | cal_ok;
  end

  ref_interval_timer #(.W(IVL_W)) u_timer (
    .clk          (clk),
    .rst          (rst),
    .run          (cal_seen),
    .cfg_interval (cfg_interval),
    .tick         (tick)
  );

  assign group_go = (|active) && (&(~active | (idle & pending)));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
      localparam int L = c * NUM_RANKS + r;
      logic lane_go;

      if (c == 0) begin : g_primary
        assign active[L] = cfg_rank_mask[r];
      end else begin : g_secondary
        assign active[L] = cfg_rank_mask[r] & cfg_lockstep_ch;
      end

      assign lane_go = cal_ok && active[L] && (!cfg_group || group_go);

      ref_lane #(.MAX_OWED(MAX_OWED), .TO_W(TO_W)) u_lane (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick & active[L]),
        .go          (lane_go),
        .ack_s       (ack_s[L]),
        .cfg_timeout (cfg_ack_timeout),
        .en          (ref_en[L]),
        .idle        (idle[L]),
        .pending     (pending[L]),
        .owed_hi     (owed_hi[L]),
        .timeout     (ack_timeout[L])
      );
    end
  end

  always_ff @(posedge clk) begin
    if (rst) owed_err <= 1'b0;
    else     owed_err <= owed_err | (|owed_hi);
  end
endmodule

// File: rtl/ref_req_gen_chk.sv
module ref_req_gen_chk #(
  parameter int LANES = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [LANES-1:0] ref_en,
  input logic [LANES-1:0] ack_s,
  input logic [LANES-1:0] active,
  input logic [LANES-1:0] ack_timeout,
  input logic             cal_ok,
  input logic             cfg_group
);
  logic seen;

  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else     seen <= seen | cal_ok;
  end

  a_r1_quiet_until_cal: assert property (@(posedge clk) disable iff (rst)
    !seen |-> (ref_en == '0));

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    a_r2_rise_on_ack_low: assert property (@(posedge clk) disable iff (rst)
      $rose(ref_en[i]) |-> !$past(ack_s[i]));

    a_r2_fall_on_ack_high: assert property (@(posedge clk) disable iff (rst)
      $fell(ref_en[i]) |-> $past(ack_s[i]));

    a_r9_timeout_holds_en: assert property (@(posedge clk) disable iff (rst)
      $rose(ack_timeout[i]) |-> ref_en[i]);

    a_r12_start_needs_cal: assert property (@(posedge clk) disable iff (rst)
      $rose(ref_en[i]) |-> $past(cal_ok));

    a_r6_inactive_silent: assert property (@(posedge clk) disable iff (rst)
      $rose(ref_en[i]) |-> $past(active[i]));

    a_r10_group_together: assert property (@(posedge clk) disable iff (rst)
      ($rose(ref_en[i]) && $past(cfg_group)) |-> ((ref_en & $past(active)) == $past(active)));
  end
endmodule

bind ref_req_gen ref_req_gen_chk #(.LANES(LANES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ref_en      (ref_en),
  .ack_s       (ack_s),
  .active      (active),
  .ack_timeout (ack_timeout),
  .cal_ok      (cal_ok),
  .cfg_group   (cfg_group)
);

// File: tb/test_ref_req_gen.sv
module test_ref_req_gen;
  localparam int NR = 4;
  localparam int NC = 2;
  localparam int L  = NR * NC;
  localparam int SYNC = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cal = 1'b0;
  logic [L-1:0]  ack = '0;
  logic [15:0]   cfg_interval = 16'd40;
  logic [NR-1:0] cfg_mask = '0;
  logic          cfg_group = 1'b0;
  logic          cfg_lock = 1'b0;
  logic [7:0]    cfg_to = 8'd0;
  logic [L-1:0]  ref_en;
  logic          owed_err;
  logic [L-1:0]  ack_timeout;

  ref_req_gen i_ref_req_gen (
    .clk(clk), .rst(rst), .cal_done_async(cal), .ref_ack_async(ack),
    .cfg_interval(cfg_interval), .cfg_rank_mask(cfg_mask), .cfg_group(cfg_group),
    .cfg_lockstep_ch(cfg_lock), .cfg_ack_timeout(cfg_to),
    .ref_en(ref_en), .owed_err(owed_err), .ack_timeout(ack_timeout)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nchecks = 0, nerr = 0;
  bit done = 0;

  int dly [L];
  bit silent [L];
  int rcnt [L];
  int rises [L];
  int maxgap [L];
  int last_rise [L];
  int ack_rise_cyc [L];
  int min_lat, proto_err, grp_err;
  logic [L-1:0] en_q = '0;

  function automatic logic [L-1:0] act_mask();
    return {(cfg_lock ? cfg_mask : {NR{1'b0}}), cfg_mask};
  endfunction

  always @(negedge clk) begin
    logic [L-1:0] rmask;
    if (rst) begin
      ack = '0;
      for (int i = 0; i < L; i++) rcnt[i] = 0;
    end else begin
      rmask = ref_en & ~en_q;
      for (int i = 0; i < L; i++) begin
        if (rmask[i]) begin
          if (ack[i]) proto_err++;
          rises[i]++;
          if (last_rise[i] >= 0 && cyc - last_rise[i] > maxgap[i]) maxgap[i] = cyc - last_rise[i];
          last_rise[i] = cyc;
        end
        if (en_q[i] && !ref_en[i]) begin
          if (!ack[i]) proto_err++;
          if (cyc - ack_rise_cyc[i] < min_lat) min_lat = cyc - ack_rise_cyc[i];
        end
      end
      if (cfg_group && rmask != '0 && rmask != act_mask()) grp_err++;
      for (int i = 0; i < L; i++) begin
        if (silent[i] || ref_en[i] == ack[i]) rcnt[i] = 0;
        else if (rcnt[i] >= dly[i]) begin
          ack[i] = ref_en[i];
          if (ref_en[i]) ack_rise_cyc[i] = cyc;
          rcnt[i] = 0;
        end else rcnt[i]++;
      end
    end
    en_q = ref_en;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_stats();
    @(posedge clk);
    for (int i = 0; i < L; i++) begin
      rises[i] = 0; maxgap[i] = 0; last_rise[i] = -1;
    end
    min_lat = 1000000; proto_err = 0; grp_err = 0;
  endtask

  task automatic do_reset(input bit cal_v);
    rst = 1'b1;
    cal = cal_v;
    for (int i = 0; i < L; i++) begin dly[i] = 1; silent[i] = 0; end
    repeat (5) @(posedge clk);
    rst = 1'b0;
    clear_stats();
  endtask

  task automatic t_reset();
    cfg_mask = 4'b1111; cfg_interval = 16'd20;
    do_reset(1'b0);
    @(negedge clk);
    chk(ref_en == '0, "R1 reset enables", int'(ref_en), 0);
    chk(owed_err == 1'b0, "R8 reset err", int'(owed_err), 0);
    chk(ack_timeout == '0, "R9 reset timeout", int'(ack_timeout), 0);
  endtask

  task automatic t_no_cal();
    int t0;
    cfg_mask = 4'b1111; cfg_interval = 16'd20; cfg_group = 0; cfg_lock = 0;
    do_reset(1'b0);
    repeat (200) @(negedge clk);
    chk(rises[0] + rises[3] == 0, "R1 no enable before cal", rises[0] + rises[3], 0);
    t0 = cyc;
    cal = 1'b1;
    while (!ref_en[0] && cyc - t0 < 500) @(negedge clk);
    chk(cyc - t0 >= 20, "R1 no refresh owed before cal", cyc - t0, 20);
    chk(ref_en[0] == 1'b1, "R1 requests after cal", int'(ref_en[0]), 1);
  endtask

  task automatic t_basic();
    cfg_mask = 4'b1011; cfg_interval = 16'd40; cfg_group = 0; cfg_lock = 0; cfg_to = 0;
    do_reset(1'b1);
    dly[0] = 0; dly[1] = 3; dly[3] = 2;
    repeat (3) @(negedge clk);
    clear_stats();
    repeat (800) @(negedge clk);
    chk(rises[0] >= 19 && rises[0] <= 21, "R5 count per interval", rises[0], 20);
    chk(rises[1] == rises[0] && rises[3] == rises[0], "R6 equal counts", rises[3], rises[0]);
    chk(rises[2] == 0 && rises[4] == 0, "R6 inactive lane silent", rises[2] + rises[4], 0);
    chk(rises[5] + rises[6] + rises[7] == 0, "R11 ch1 off", rises[5] + rises[6] + rises[7], 0);
    chk(proto_err == 0, "R2 handshake order", proto_err, 0);
    chk(min_lat >= SYNC + 1, "R4 ack sync latency", min_lat, SYNC + 1);
    chk(maxgap[0] <= 7 * 40 && maxgap[3] <= 7 * 40, "R7 max gap", maxgap[3], 280);
    chk(owed_err == 1'b0, "R8 no err when keeping up", int'(owed_err), 0);
    cfg_interval = 16'd0;
    repeat (40) @(negedge clk);
    clear_stats();
    repeat (200) @(negedge clk);
    chk(rises[0] == 0, "R5 interval 0 stops timer", rises[0], 0);
  endtask

  task automatic t_lockstep();
    cfg_mask = 4'b1111; cfg_interval = 16'd30; cfg_group = 0; cfg_lock = 1;
    do_reset(1'b1);
    dly[5] = 4; dly[7] = 0;
    repeat (3) @(negedge clk);
    clear_stats();
    repeat (600) @(negedge clk);
    chk(rises[0] > 0, "R11 ch0 served", rises[0], 20);
    chk(rises[4] == rises[0] && rises[7] == rises[0], "R11 ch1 lockstep counts", rises[7], rises[0]);
    chk(proto_err == 0, "R2 handshake order lockstep", proto_err, 0);
  endtask

  task automatic t_stall();
    int t0;
    cfg_mask = 4'b0011; cfg_interval = 16'd50; cfg_group = 0; cfg_lock = 0; cfg_to = 8'd30;
    do_reset(1'b1);
    silent[1] = 1;
    while (!ref_en[1]) @(negedge clk);
    t0 = cyc;
    repeat (15) @(negedge clk);
    chk(ack_timeout[1] == 1'b0, "R9 no early timeout", int'(ack_timeout[1]), 0);
    repeat (25) @(negedge clk);
    chk(ack_timeout[1] == 1'b1, "R9 timeout flagged", int'(ack_timeout[1]), 1);
    chk(ref_en[1] == 1'b1, "R9 enable held", int'(ref_en[1]), 1);
    chk(ack_timeout[0] == 1'b0, "R9 other lane no timeout", int'(ack_timeout[0]), 0);
    clear_stats();
    while (cyc - t0 < 3 * 50) @(negedge clk);
    chk(owed_err == 1'b0, "R8 err not before limit", int'(owed_err), 0);
    while (cyc - t0 < 8 * 50) @(negedge clk);
    chk(owed_err == 1'b1, "R8 err at limit", int'(owed_err), 1);
    chk(rises[0] >= 5, "R3 other lane still served", rises[0], 6);
  endtask

  task automatic t_group();
    cfg_mask = 4'b1111; cfg_interval = 16'd40; cfg_group = 1; cfg_lock = 0; cfg_to = 0;
    do_reset(1'b1);
    dly[0] = 0; dly[1] = 5; dly[2] = 12; dly[3] = 2;
    repeat (3) @(negedge clk);
    clear_stats();
    repeat (600) @(negedge clk);
    chk(grp_err == 0, "R10 group starts aligned", grp_err, 0);
    chk(rises[0] > 0 && rises[2] == rises[0] && rises[1] == rises[0], "R10 group counts", rises[2], rises[0]);
    cfg_group = 0;
  endtask

  task automatic t_cal_drop();
    cfg_mask = 4'b0001; cfg_interval = 16'd40; cfg_group = 0; cfg_lock = 0; cfg_to = 0;
    do_reset(1'b1);
    dly[0] = 10;
    while (!ref_en[0]) @(negedge clk);
    cal = 1'b0;
    repeat (40) @(negedge clk);
    chk(ref_en[0] == 1'b0, "R12 in-progress handshake completes", int'(ref_en[0]), 0);
    chk(proto_err == 0, "R12 handshake order on drop", proto_err, 0);
    clear_stats();
    repeat (200) @(negedge clk);
    chk(rises[0] == 0, "R12 no start while cal low", rises[0], 0);
    cal = 1'b1;
    repeat (60) @(negedge clk);
    chk(rises[0] > 0, "R12 backlog served after cal returns", rises[0], 1);
  endtask

  initial begin
    t_reset();
    t_no_cal();
    t_basic();
    t_lockstep();
    t_stall();
    t_group();
    t_cal_drop();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchecks++;
      nerr++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
      $finish;
    end
  end
endmodule